// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block turns interrupt events raised inside the chip into fixed 16-byte vectors and stores them, one after another, in a circular buffer in memory. Each event arrives on a valid/ready stream that carries a source identifier, 28 bits of source data, a ring identifier, a VM identifier and a process address-space identifier. The block packs these fields into four 32-bit words, writes the words through a plain word-write memory port with its own valid/ready handshake, and then advances a byte-counting write pointer. Software drains the ring by reading vectors from memory and moving a read pointer register forward. While unread vectors remain, a level interrupt stays high.

Software controls the block through a small word-wide register port. It sets the ring base, its size as a power of two, whether a full ring stalls new events or overwrites the oldest entry, and whether the write pointer is copied to memory after every vector. Back-pressure rules: an event is accepted only on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` does not depend on `ev_valid`, and it is low while a vector or writeback is in flight. A memory word is transferred only on a clock edge where `mem_valid` and `mem_ready` are both high. Until that edge, address and data hold still.

Top module: `ivr_writer`

## Requirements
- R1: Each accepted event is written as four words at ring base + write pointer + 0, 4, 8, 12, in that order. Word 0 holds the source id in [7:0] with zero above it. Word 1 holds the source data in [27:0] with zero above it. Word 2 holds the ring id in [7:0], the VM id in [15:8] and the address-space id in [31:16]. Word 3 is zero.
- R2: The write pointer counts bytes and advances by 16 when a vector's last word is accepted. It wraps modulo the ring byte size, which is 4·2^S. S is CTRL[8:5], clamped to the range 3..MAX_LOG2. The ring base is 16-byte aligned.
- R3: `irq` is high exactly when ring enable CTRL[0] and interrupt enable CTRL[1] are both set and either the read and write pointers differ or the overflow flag is set. The rearm gap of R10 is the only exception.
- R4: `ev_ready` is low unless CTRL[0] and CTRL[1] are both set and no vector or writeback is in flight. STATUS (offset 5) bit 0 reads 1 while one is in flight.
- R5: With overflow detection CTRL[2] clear, an event whose write would make the write pointer equal the read pointer is stalled (`ev_ready` low, nothing written) until the read pointer moves.
- R6: With CTRL[2] set, such an event is still written, the write pointer still advances, and a sticky overflow flag is set. The flag reads as bit 0 of the WPTR register (offset 4).
- R7: Writing CTRL with bit 31 set clears the overflow flag. Bit 31 always reads back as 0.
- R8: With writeback CTRL[3] set, each vector is followed by one more memory word holding the WPTR readback value, written to the writeback address register (offset 2, word aligned).
- R9: A CTRL write with bit 0 clear, and any cycle with the ring disabled, forces the read pointer, the write pointer and the overflow flag to zero. Writes to RPTR (offset 3) or WPTR (offset 4) load the value masked to the ring size and aligned to 16 bytes. BASE is at offset 1.
- R10: With rearm CTRL[4] set, an RPTR write that leaves the pointers unequal drives `irq` low for exactly one cycle, after which it rises again.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event stream valid |
| ev_ready | output | 1 | Event stream ready |
| ev_src_id | input | 8 | Source identifier |
| ev_src_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring identifier |
| ev_vm_id | input | 8 | VM identifier |
| ev_pasid | input | 16 | Process address-space identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_data | output | 32 | Memory write data |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach from the ports are the wrap at a full ring: the stall when overflow detection is off, and the overwrite that leaves both pointers equal while `irq` stays high when it is on. The bench programs the smallest ring size, two entries, so that a second event lands exactly on the read pointer. For the stall case it also moves the read pointer so that the write pointer must wrap past zero before it meets it. Memory back-pressure is reached by holding `mem_ready` low after an event has been accepted, and the one-cycle rearm gap is sampled on the exact cycles after the read-pointer write.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int WORD_W    = 32;
  localparam int VEC_WORDS = 4;
  localparam int VEC_BYTES = VEC_WORDS * 4;
  localparam int IDX_W     = $clog2(VEC_WORDS);
  localparam int REG_AW    = 3;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_BASE = 3'd1;
  localparam logic [REG_AW-1:0] A_WBAD = 3'd2;
  localparam logic [REG_AW-1:0] A_RPTR = 3'd3;
  localparam logic [REG_AW-1:0] A_WPTR = 3'd4;
  localparam logic [REG_AW-1:0] A_STAT = 3'd5;

  localparam int C_RING  = 0;
  localparam int C_INTR  = 1;
  localparam int C_OVFD  = 2;
  localparam int C_WB    = 3;
  localparam int C_REARM = 4;
  localparam int C_SZLO  = 5;
  localparam int C_SZHI  = 8;
  localparam int C_OCLR  = 31;

  typedef struct packed {
    logic [7:0]  src;
    logic [27:0] data;
    logic [7:0]  ring;
    logic [7:0]  vm;
    logic [15:0] pasid;
  } ivr_event_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_VEC, SQ_WB} seq_state_e;
endpackage

// File: rtl/ivr_pack.sv
module ivr_pack
  import ivr_pkg::*;
(
  input  ivr_event_t                         ev,
  output logic [VEC_WORDS-1:0][WORD_W-1:0]   words
);
  always_comb begin
    words    = '0;
    words[0] = {24'b0, ev.src};
    words[1] = {4'b0, ev.data};
    words[2] = {ev.pasid, ev.vm, ev.ring};
  end
endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter  int ADDR_W   = 32,
  parameter  int MAX_LOG2 = 14,
  parameter  int MIN_LOG2 = 3,
  localparam int PTR_W    = MAX_LOG2 + 2,
  localparam int SZ_W     = C_SZHI - C_SZLO + 1
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                vec_done,
  input  logic                busy,
  output logic                room,
  output logic                wb_on,
  output logic                ovf_det,
  output logic [ADDR_W-1:0]   ring_base,
  output logic [ADDR_W-1:0]   wb_addr,
  output logic [PTR_W-1:0]    wptr,
  output logic                ovf,
  output logic [WORD_W-1:0]   wptr_word,
  output logic                irq
);
  logic              ring_q, intr_q, ovfd_q, wb_q, rearm_q, gap_q, ovf_q;
  logic [SZ_W-1:0]   sz_q, sz_eff;
  logic [ADDR_W-1:0] base_q, wbad_q;
  logic [PTR_W-1:0]  wptr_q, rptr_q, mask, next_w, wr_ptr_val;
  logic              wr_ctrl, wr_base, wr_wbad, wr_rptr, wr_wptr, ring_clr;

  always_comb begin
    if (sz_q < SZ_W'(MIN_LOG2))      sz_eff = SZ_W'(MIN_LOG2);
    else if (sz_q > SZ_W'(MAX_LOG2)) sz_eff = SZ_W'(MAX_LOG2);
    else                             sz_eff = sz_q;
  end

  assign mask       = {PTR_W{1'b1}} >> (MAX_LOG2 - int'(sz_eff));
  assign next_w     = (wptr_q + PTR_W'(VEC_BYTES)) & mask;
  assign wr_ptr_val = reg_wdata[PTR_W-1:0] & mask & ~PTR_W'(VEC_BYTES - 1);

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_base  = reg_wr && (reg_addr == A_BASE);
  assign wr_wbad  = reg_wr && (reg_addr == A_WBAD);
  assign wr_rptr  = reg_wr && (reg_addr == A_RPTR);
  assign wr_wptr  = reg_wr && (reg_addr == A_WPTR);
  assign ring_clr = !ring_q || (wr_ctrl && !reg_wdata[C_RING]);

  // control fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_q  <= 1'b0;
      intr_q  <= 1'b0;
      ovfd_q  <= 1'b0;
      wb_q    <= 1'b0;
      rearm_q <= 1'b0;
      sz_q    <= '0;
      base_q  <= '0;
      wbad_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ring_q  <= reg_wdata[C_RING];
        intr_q  <= reg_wdata[C_INTR];
        ovfd_q  <= reg_wdata[C_OVFD];
        wb_q    <= reg_wdata[C_WB];
        rearm_q <= reg_wdata[C_REARM];
        sz_q    <= reg_wdata[C_SZHI:C_SZLO];
      end
      if (wr_base) base_q <= {reg_wdata[ADDR_W-1:4], 4'b0};
      if (wr_wbad) wbad_q <= {reg_wdata[ADDR_W-1:2], 2'b0};
    end
  end

  // pointers, overflow flag and rearm gap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      if (ring_clr)      wptr_q <= '0;
      else if (wr_wptr)  wptr_q <= wr_ptr_val;
      else if (vec_done) wptr_q <= next_w;

      if (ring_clr)     rptr_q <= '0;
      else if (wr_rptr) rptr_q <= wr_ptr_val;

      if (ring_clr)                                  ovf_q <= 1'b0;
      else if (vec_done && ovfd_q && next_w == rptr_q) ovf_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[C_OCLR])         ovf_q <= 1'b0;

      gap_q <= wr_rptr && rearm_q && !ring_clr && (wr_ptr_val != wptr_q);
    end
  end

  assign wptr_word = WORD_W'(wptr_q) | WORD_W'(ovf_q);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = WORD_W'({sz_q, rearm_q, wb_q, ovfd_q, intr_q, ring_q});
      A_BASE:  reg_rdata = WORD_W'(base_q);
      A_WBAD:  reg_rdata = WORD_W'(wbad_q);
      A_RPTR:  reg_rdata = WORD_W'(rptr_q);
      A_WPTR:  reg_rdata = wptr_word;
      A_STAT:  reg_rdata = WORD_W'(busy);
      default: reg_rdata = '0;
    endcase
  end

  assign room      = ring_q && intr_q && (ovfd_q || (next_w != rptr_q));
  assign irq       = ring_q && intr_q && ((rptr_q != wptr_q) || ovf_q) && !gap_q;
  assign wb_on     = wb_q;
  assign ovf_det   = ovfd_q;
  assign ring_base = base_q;
  assign wb_addr   = wbad_q;
  assign wptr      = wptr_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ev_valid,
  output logic                              ev_ready,
  input  logic [VEC_WORDS-1:0][WORD_W-1:0]  ev_words,
  input  logic                              room,
  input  logic [ADDR_W-1:0]                 ring_base,
  input  logic [PTR_W-1:0]                  wptr,
  input  logic                              wb_on,
  input  logic [ADDR_W-1:0]                 wb_addr,
  input  logic [WORD_W-1:0]                 wb_word,
  output logic                              mem_valid,
  input  logic                              mem_ready,
  output logic [ADDR_W-1:0]                 mem_addr,
  output logic [WORD_W-1:0]                 mem_data,
  output logic                              vec_done,
  output logic                              busy
);
  seq_state_e                        state_q;
  logic [IDX_W-1:0]                  idx_q;
  logic [ADDR_W-1:0]                 slot_q;
  logic [VEC_WORDS-1:0][WORD_W-1:0]  words_q;
  logic                              last_word;

  assign ev_ready  = (state_q == SQ_IDLE) && room;
  assign last_word = (idx_q == IDX_W'(VEC_WORDS - 1));
  assign vec_done  = (state_q == SQ_VEC) && mem_ready && last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      slot_q  <= '0;
      words_q <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (ev_valid && ev_ready) begin
          words_q <= ev_words;
          slot_q  <= ring_base + ADDR_W'(wptr);
          idx_q   <= '0;
          state_q <= SQ_VEC;
        end
        SQ_VEC: if (mem_ready) begin
          if (last_word) begin
            idx_q   <= '0;
            state_q <= wb_on ? SQ_WB : SQ_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SQ_WB: if (mem_ready) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = (state_q != SQ_IDLE);
    if (state_q == SQ_WB) begin
      mem_addr = wb_addr;
      mem_data = wb_word;
    end else begin
      mem_addr = slot_q + ADDR_W'({idx_q, 2'b00});
      mem_data = words_q[idx_q];
    end
  end

  assign busy = (state_q != SQ_IDLE);
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 14,
  parameter int MIN_LOG2 = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [7:0]        ev_src_id,
  input  logic [27:0]       ev_src_data,
  input  logic [7:0]        ev_ring_id,
  input  logic [7:0]        ev_vm_id,
  input  logic [15:0]       ev_pasid,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              irq
);
  localparam int PTR_W = MAX_LOG2 + 2;

  ivr_event_t                        ev;
  logic [VEC_WORDS-1:0][WORD_W-1:0]  ev_words;
  logic                              room, wb_on, ovf_det, ovf_flag, vec_done, busy;
  logic [ADDR_W-1:0]                 ring_base, wb_addr;
  logic [PTR_W-1:0]                  wptr_q;
  logic [WORD_W-1:0]                 wptr_word;

  assign ev = '{src: ev_src_id, data: ev_src_data, ring: ev_ring_id,
                vm: ev_vm_id, pasid: ev_pasid};

  ivr_pack u_pack (.ev(ev), .words(ev_words));

  ivr_regs #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .MIN_LOG2(MIN_LOG2)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_done(vec_done), .busy(busy), .room(room), .wb_on(wb_on), .ovf_det(ovf_det),
    .ring_base(ring_base), .wb_addr(wb_addr), .wptr(wptr_q), .ovf(ovf_flag),
    .wptr_word(wptr_word), .irq(irq)
  );

  ivr_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_words(ev_words), .room(room),
    .ring_base(ring_base), .wptr(wptr_q), .wb_on(wb_on), .wb_addr(wb_addr),
    .wb_word(wptr_word), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .vec_done(vec_done), .busy(busy)
  );
endmodule

// File: rtl/ivr_writer_chk.sv
module ivr_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic              ring_off_wr,
  input logic              irq,
  input logic [PTR_W-1:0]  wptr,
  input logic              ovf,
  input logic              ovf_det,
  input logic              busy
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R4
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |-> !busy);

  // R1
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> mem_valid && busy);

  // R9
  ring_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_off_wr |=> (wptr == '0) && !ovf && !irq);

  // R6
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(ovf_det));
endmodule

bind ivr_writer ivr_writer_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .ring_off_wr(reg_wr && (reg_addr == 3'd0) && !reg_wdata[0]),
  .irq(irq), .wptr(wptr_q), .ovf(ovf_flag), .ovf_det(ovf_det), .busy(busy)
);

// File: tb/tb_ivr_writer.sv
module tb_ivr_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ev_valid = 1'b0;
  logic              ev_ready;
  logic [7:0]        ev_src_id = '0;
  logic [27:0]       ev_src_data = '0;
  logic [7:0]        ev_ring_id = '0;
  logic [7:0]        ev_vm_id = '0;
  logic [15:0]       ev_pasid = '0;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_valid;
  logic              mem_ready = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_data;
  logic              irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ivr_writer dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src_id(ev_src_id), .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id),
    .ev_vm_id(ev_vm_id), .ev_pasid(ev_pasid), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
  );

  always @(posedge clk) if (mem_valid && mem_ready) mem[mem_addr[9:2]] <= mem_data;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_ev(input logic [7:0] s, input logic [27:0] dt,
                         input logic [7:0] rg, input logic [7:0] vm, input logic [15:0] pa);
    ev_src_id = s; ev_src_data = dt; ev_ring_id = rg; ev_vm_id = vm; ev_pasid = pa;
    ev_valid = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (ev_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 200; i++) begin
      rd_reg(3'd5, st);
      if (st[0] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic [31:0] ctrl);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd0, ctrl);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R4 ev_ready after reset", 32'(ev_ready), 32'd0);
    chk("R3 irq after reset", 32'(irq), 32'd0);
    chk("R11 mem_valid after reset", 32'(mem_valid), 32'd0);
    rd_reg(3'd4, v);
    chk("R2 wptr after reset", v, 32'd0);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    wr_reg(3'd1, 32'h100);
    restart(32'h83);
    send_ev(8'hA5, 28'hABCDEF1, 8'h12, 8'h34, 16'h5678);
    wait_idle();
    chk("R1 word0", mem[64], 32'h0000_00A5);
    chk("R1 word1", mem[65], 32'h0ABC_DEF1);
    chk("R1 word2", mem[66], 32'h5678_3412);
    chk("R1 word3", mem[67], 32'h0);
    rd_reg(3'd4, v);
    chk("R2 wptr after one vector", v, 32'd16);
    chk("R3 irq pending", 32'(irq), 32'd1);
    send_ev(8'h3C, 28'h1, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R1 second slot", mem[68], 32'h3C);
    rd_reg(3'd4, v);
    chk("R2 wptr after two vectors", v, 32'd32);
  endtask

  task automatic t_wrap_stall();
    logic [31:0] v;
    wr_reg(3'd3, 32'd32);
    chk("R3 irq low when drained", 32'(irq), 32'd0);
    send_ev(8'h03, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    send_ev(8'h04, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R1 fourth slot", mem[76], 32'h04);
    rd_reg(3'd4, v);
    chk("R2 wrap to zero", v, 32'd0);
    send_ev(8'h05, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R2 wrapped slot", mem[64], 32'h05);
    ev_src_id = 8'h06; ev_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 stall ev_ready", 32'(ev_ready), 32'd0);
    chk("R5 stall no write", 32'(mem_valid), 32'd0);
    rd_reg(3'd4, v);
    chk("R5 wptr held", v, 32'd16);
    ev_valid = 1'b0;
    wr_reg(3'd3, 32'd48);
    send_ev(8'h06, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R5 released write", mem[68], 32'h06);
    rd_reg(3'd4, v);
    chk("R5 wptr after release", v, 32'd32);
  endtask

  task automatic t_gate();
    wr_reg(3'd0, 32'h81);
    ev_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 intr off blocks", 32'(ev_ready), 32'd0);
    chk("R3 irq off with intr disabled", 32'(irq), 32'd0);
    ev_valid = 1'b0;
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr_reg(3'd0, 32'h0);
    rd_reg(3'd4, v);
    chk("R9 wptr cleared", v, 32'd0);
    rd_reg(3'd3, v);
    chk("R9 rptr cleared", v, 32'd0);
    wr_reg(3'd0, 32'h83);
    wr_reg(3'd3, 32'h35);
    rd_reg(3'd3, v);
    chk("R9 rptr masked aligned", v, 32'h30);
    chk("R3 irq when unequal", 32'(irq), 32'd1);
    wr_reg(3'd4, 32'h30);
    rd_reg(3'd4, v);
    chk("R9 wptr loaded", v, 32'h30);
    chk("R3 irq when equal", 32'(irq), 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    restart(32'h67);
    send_ev(8'hB1, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    send_ev(8'hB2, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R6 write on full", mem[68], 32'hB2);
    rd_reg(3'd4, v);
    chk("R6 sticky flag in wptr", v, 32'd1);
    chk("R3 irq from flag", 32'(irq), 32'd1);
    wr_reg(3'd0, 32'h8000_0067);
    rd_reg(3'd4, v);
    chk("R7 flag cleared", v, 32'd0);
    rd_reg(3'd0, v);
    chk("R7 clear bit reads 0", v, 32'h67);
    chk("R3 irq after clear", 32'(irq), 32'd0);
  endtask

  task automatic t_writeback();
    restart(32'h8B);
    wr_reg(3'd2, 32'h3F0);
    mem[252] = 32'hDEAD_BEEF;
    send_ev(8'hC7, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R8 writeback value", mem[252], 32'd16);
    chk("R8 vector still written", mem[64], 32'hC7);
  endtask

  task automatic t_rearm();
    restart(32'h93);
    send_ev(8'h01, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    send_ev(8'h02, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_idle();
    wr_reg(3'd3, 32'd16);
    chk("R10 gap cycle", 32'(irq), 32'd0);
    @(negedge clk);
    chk("R10 irq back", 32'(irq), 32'd1);
    wr_reg(3'd0, 32'h83);
    wr_reg(3'd3, 32'd0);
    chk("R10 no gap without rearm", 32'(irq), 32'd1);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    restart(32'h83);
    mem_ready = 1'b0;
    send_ev(8'hE9, 28'h0, 8'h0, 8'h0, 16'h0);
    for (int i = 0; i < 3; i++) begin
      chk("R11 valid held", 32'(mem_valid), 32'd1);
      chk("R11 addr held", mem_addr, 32'h100);
      chk("R11 data held", mem_data, 32'hE9);
      @(negedge clk);
    end
    rd_reg(3'd5, v);
    chk("R4 busy while stalled", v, 32'd1);
    chk("R4 no accept while busy", 32'(ev_ready), 32'd0);
    mem_ready = 1'b1;
    wait_idle();
    rd_reg(3'd5, v);
    chk("R4 busy clears", v, 32'd0);
    chk("R11 word landed", mem[64], 32'hE9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_vector();
    t_wrap_stall();
    t_gate();
    t_disable();
    t_overflow();
    t_writeback();
    t_rearm();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule